// File: doc/BRIEF.md
# Context Save and Restore Sequencer

This block moves processor context between a register file and a system stack in memory. When an event is taken, it writes the state of the interrupted code onto the stack. When the handler finishes, it reads that state back. It moves one stack word per clock cycle. It drives a single word-wide memory port and a register-file port that has one read index and one write index. It holds the stack pointer itself.

Entry always saves the status word and the return address. An event whose class marks it as an interrupt level also saves the five general registers R8 to R12 and the link register. Those registers are written first, so the status word and return address sit on top. A return reads the words back in the opposite order. It uses the frame size of the most recent entry. Once a sequence has started, it runs to the end without interruption. A push that would go below a fixed lowest stack address is not written to memory. Instead it sets a sticky overflow flag.

Top module: `ctx_stacker`

## Requirements
- R1: After reset, `sp` equals `SP_RST` and `busy`, `done` and `ovf` are 0.
- R2: An entry with `ev_cls` in 0..3 (interrupt level) pushes 8 words. In time order the register indices are 2,3,4,5,6,7,0,1, written to addresses sp-1 down to sp-8. Register index encoding: 0 status, 1 return address, 2..6 R8..R12, 7 link register.
- R3: An entry with `ev_cls` in 4..7 pushes only the status word (index 0) to sp-1, then the return address (index 1) to sp-2.
- R4: Each push writes to sp-1 and decrements `sp` by one, so an entry leaves `sp` lower by the frame size.
- R5: A return pops in the exact reverse of the push order. It reads `mem_addr` = sp, writes that word to the matching register index, and increments `sp`. The pops restore both the register values and `sp`.
- R6: A return pops 8 words if the latest entry had class 0..3, and 2 words otherwise. Registers outside the frame are not written.
- R7: The first word moves in the cycle after the start input is sampled. One word moves per cycle. `busy` is high for exactly 8 or 2 cycles. `done` is a single-cycle pulse in the cycle after the last word.
- R8: `ent_go`, `ret_go` and `sp_ld` are ignored while `busy` is high. If `ent_go` and `ret_go` are sampled together, entry wins.
- R9: A push whose target address is below `LIM` is not written to memory, but `sp` still decrements. The push sets `ovf`, which stays set until reset.
- R10: When idle and neither start input is high, `sp_ld` loads `sp_din` into `sp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_go | input | 1 | Start an entry save |
| ev_cls | input | 3 | Event class; 0..3 interrupt levels |
| ret_go | input | 1 | Start a return restore |
| sp_ld | input | 1 | Load stack pointer when idle |
| sp_din | input | AW | Stack pointer load value |
| sp | output | AW | Stack pointer (word address) |
| mem_addr | output | AW | Stack memory word address |
| mem_we | output | 1 | Stack memory write enable |
| mem_wdata | output | W | Stack memory write data |
| mem_rdata | input | W | Stack memory read data (same cycle) |
| rf_ridx | output | 3 | Register read index |
| rf_rdata | input | W | Register read data (same cycle) |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 3 | Register write index |
| rf_wdata | output | W | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ovf | output | 1 | Sticky stack overflow flag |

## Verification
A start input sampled at edge E0 makes the block move its first word between E0 and E1. The last word of an n-word frame moves between E(n-1) and En, and `done` is high for the cycle after En. The bench raises the start input at a falling edge and lowers it after one rising edge. It then counts, on falling edges, how many samples show `busy` high before `done` appears, and expects exactly 8 or 2. The bench compares memory contents, register contents, `sp` and `ovf` against values computed from the push order only after `done` is seen, which is one cycle after the last write has landed. It checks `done` again on the next falling edge to confirm that the pulse lasts one cycle.

// File: rtl/ctx_stacker.sv
module ctx_stacker #(
  parameter int W      = 32,
  parameter int AW     = 8,
  parameter int SP_RST = 240,
  parameter int LIM    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent_go,
  input  logic [2:0]    ev_cls,
  input  logic          ret_go,
  input  logic          sp_ld,
  input  logic [AW-1:0] sp_din,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic [2:0]    rf_ridx,
  input  logic [W-1:0]  rf_rdata,
  output logic          rf_we,
  output logic [2:0]    rf_widx,
  output logic [W-1:0]  rf_wdata,
  output logic          busy,
  output logic          done,
  output logic          ovf
);
  localparam logic [2:0] FULL_FIRST  = 3'd0;
  localparam logic [2:0] SHORT_FIRST = 3'd6;
  localparam logic [2:0] TOP_STEP    = 3'd7;

  logic       pop;
  logic       irq_frm;
  logic [2:0] step;
  logic [2:0] idx;
  logic       push_ok;
  logic       last;

  assign idx      = (step < 3'd6) ? step + 3'd2 : step - 3'd6;
  assign push_ok  = ({1'b0, sp} > (AW+1)'(LIM));
  assign last     = pop ? (step == (irq_frm ? FULL_FIRST : SHORT_FIRST)) : (step == TOP_STEP);

  assign mem_addr  = pop ? sp : sp - 1'b1;
  assign mem_we    = busy & ~pop & push_ok;
  assign mem_wdata = rf_rdata;
  assign rf_ridx   = idx;
  assign rf_widx   = idx;
  assign rf_we     = busy & pop;
  assign rf_wdata  = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp      <= AW'(SP_RST);
      busy    <= 1'b0;
      done    <= 1'b0;
      ovf     <= 1'b0;
      pop     <= 1'b0;
      irq_frm <= 1'b0;
      step    <= 3'd0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (ent_go) begin
          busy    <= 1'b1;
          pop     <= 1'b0;
          irq_frm <= ~ev_cls[2];
          step    <= ev_cls[2] ? SHORT_FIRST : FULL_FIRST;
        end else if (ret_go) begin
          busy <= 1'b1;
          pop  <= 1'b1;
          step <= TOP_STEP;
        end else if (sp_ld) begin
          sp <= sp_din;
        end
      end else begin
        if (pop) begin
          sp <= sp + 1'b1;
        end else begin
          sp <= sp - 1'b1;
          if (!push_ok) ovf <= 1'b1;
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= pop ? step - 3'd1 : step + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/ctx_stacker_chk.sv
module ctx_stacker_chk #(
  parameter int W   = 32,
  parameter int AW  = 8,
  parameter int LIM = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] sp,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          rf_we,
  input logic          busy,
  input logic          done,
  input logic          ovf
);
  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 1'b1);

  assert_pop_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> sp == $past(sp) + 1'b1);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_moves_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || rf_we) |-> busy);

  assert_one_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, rf_we}));

  assert_no_low_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} >= (AW+1)'(LIM)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

bind ctx_stacker ctx_stacker_chk #(.W(W), .AW(AW), .LIM(LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we),
  .rf_we(rf_we), .busy(busy), .done(done), .ovf(ovf)
);

// File: tb/sim_ctx_stacker.sv
`timescale 1ns/1ps
module sim_ctx_stacker;
  localparam int W = 32, AW = 8, SP_RST = 240, LIM = 16;

  logic clk = 0, rst_n = 0;
  logic ent_go = 0, ret_go = 0, sp_ld = 0;
  logic [2:0] ev_cls = 0;
  logic [AW-1:0] sp_din = 0, sp, mem_addr;
  logic mem_we, rf_we, busy, done, ovf;
  logic [W-1:0] mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [2:0] rf_ridx, rf_widx;

  logic [W-1:0] mem [256];
  logic [W-1:0] rf [8];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  assign rf_rdata  = rf[rf_ridx];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (rf_we)  rf[rf_widx]   <= rf_wdata;
  end

  ctx_stacker #(.W(W), .AW(AW), .SP_RST(SP_RST), .LIM(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .ent_go(ent_go), .ev_cls(ev_cls), .ret_go(ret_go),
    .sp_ld(sp_ld), .sp_din(sp_din), .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_ridx(rf_ridx), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata), .busy(busy), .done(done), .ovf(ovf)
  );

  function automatic int frame_len(logic [2:0] c);
    return c < 4 ? 8 : 2;
  endfunction

  function automatic int push_reg(logic [2:0] c, int k);
    int full [8] = '{2, 3, 4, 5, 6, 7, 0, 1};
    return c < 4 ? full[k] : k;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_sp(logic [AW-1:0] v);
    @(negedge clk); sp_din = v; sp_ld = 1;
    @(negedge clk); sp_ld = 0;
  endtask

  task automatic run(bit ent, bit ret, logic [2:0] c, output int n);
    @(negedge clk); ent_go = ent; ret_go = ret; ev_cls = c;
    @(negedge clk); ent_go = 0; ret_go = 0;
    n = 0;
    while (!done && n < 20) begin
      if (busy) n++;
      @(negedge clk);
    end
  endtask

  task automatic fill_rf();
    for (int i = 0; i < 8; i++) rf[i] = $urandom;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] saved [8];
    logic [W-1:0] scr [8];
    logic [AW-1:0] s0;
    logic [2:0] c;
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    fill_rf();
    #12;
    chk(sp == AW'(SP_RST) && !busy && !done && !ovf, "R1 reset", {sp, busy, done, ovf}, {8'(SP_RST), 3'b000});
    rst_n = 1;

    for (int it = 0; it < 40; it++) begin
      c = (it < 2) ? 3'(it * 4) : 3'($urandom_range(0, 7));
      s0 = AW'($urandom_range(LIM + 10, 250));
      load_sp(s0);
      chk(sp == s0, "R10 sp load", sp, s0);
      fill_rf();
      for (int i = 0; i < 8; i++) saved[i] = rf[i];
      run(1, 0, c, n);
      chk(n == frame_len(c), "R7 entry cycles", n, frame_len(c));
      chk(sp == s0 - AW'(frame_len(c)), "R4 sp after entry", sp, s0 - AW'(frame_len(c)));
      for (int k = 0; k < frame_len(c); k++)
        chk(mem[s0 - AW'(k + 1)] == saved[push_reg(c, k)], c < 4 ? "R2 push word" : "R3 push word",
            mem[s0 - AW'(k + 1)], saved[push_reg(c, k)]);
      @(negedge clk);
      chk(!done, "R7 done one cycle", done, 0);
      for (int i = 0; i < 8; i++) begin rf[i] = $urandom; scr[i] = rf[i]; end
      run(0, 1, 3'd0, n);
      chk(n == frame_len(c), "R6 return cycles", n, frame_len(c));
      chk(sp == s0, "R5 sp after return", sp, s0);
      for (int i = 0; i < 8; i++) begin
        if (c < 4 || i < 2) chk(rf[i] == saved[i], "R5 restore", rf[i], saved[i]);
        else chk(rf[i] == scr[i], "R6 untouched", rf[i], scr[i]);
      end
    end
    chk(!ovf, "R9 no overflow yet", ovf, 0);

    // R8: both starts together, entry wins; late starts and loads ignored while busy
    load_sp(8'd100);
    fill_rf();
    @(negedge clk); ent_go = 1; ret_go = 1; ev_cls = 3'd1;
    @(negedge clk); ent_go = 0; ret_go = 0;
    @(negedge clk); @(negedge clk);
    ent_go = 1; ret_go = 1; sp_ld = 1; sp_din = 8'd7; ev_cls = 3'd5;
    @(negedge clk); ent_go = 0; ret_go = 0; sp_ld = 0;
    n = 3;
    while (!done && n < 20) begin if (busy) n++; @(negedge clk); end
    chk(n == 8, "R8 atomic entry cycles", n, 8);
    chk(sp == 8'd92, "R8 entry wins and load ignored", sp, 92);
    run(0, 1, 3'd0, n);
    chk(n == 8, "R8 return keeps full frame", n, 8);

    // R9: overflow near the limit
    load_sp(AW'(LIM + 3));
    mem[LIM - 1] = 32'hCAFE_0001;
    fill_rf();
    for (int i = 0; i < 8; i++) saved[i] = rf[i];
    run(1, 0, 3'd2, n);
    chk(ovf, "R9 ovf set", ovf, 1);
    chk(sp == AW'(LIM - 5), "R9 sp still decrements", sp, LIM - 5);
    chk(mem[LIM - 1] == 32'hCAFE_0001, "R9 write suppressed", mem[LIM - 1], 32'hCAFE_0001);
    chk(mem[LIM] == saved[4], "R9 legal push kept", mem[LIM], saved[4]);
    load_sp(8'd200);
    run(1, 0, 3'd6, n);
    chk(ovf, "R9 ovf sticky", ovf, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule